// File: doc/BRIEF.md
# Phase-to-Phasor Lookup Generator

This block converts a stream of phase words into complex unit phasors. Each phase word is an unsigned fraction of one full turn. The block returns the cosine and the sine of that angle as a packed pair of signed fixed-point numbers. It is intended to sit after a phase accumulator and before a complex mixer. The mixer consumes the phasor stream in lock-step with a sample stream.

The angle is quantised to its twelve most significant bits. The top two of those bits select the quadrant. The remaining ten bits address a quarter-wave table that holds rounded sine magnitudes. The three other quadrants are produced by mirroring the address and inverting the sign. The value +1.0 is kept exact as 0x4000 rather than saturated, because it fits in the Q2.14 format.

The pipeline is three deep and moves only when a new input word is accepted. A word therefore leaves the block once two further words have been accepted after it. Trailing results are flushed by feeding dummy phases. The per-word end flag travels with its word.

Top module: `phasor_lut_gen`

## Requirements
- R1: While `rst_n` is low, and after its release until the third accepted word, `iq_valid` is 0 and `ph_ready` is 1.
- R2: Only bits [23:12] of the phase word affect the result. Two words that differ only in bits [11:0] give identical output words.
- R3: `iq_word` holds cosine in bits [15:0] and sine in bits [31:16], each a two's complement Q2.14 value. Each is within ±2 LSB of round(16384·cos(2πp/4096)) and round(16384·sin(2πp/4096)), where p = phase[23:12]. Neither half leaves the range −16384..16384.
- R4: Phase 0x000000 gives 0x0000_4000. Phase 0x400000 gives 0x4000_0000. Phase 0x800000 gives 0x0000_C000. Phase 0xC00000 gives 0xC000_0000.
- R5: The results for phases p and p XOR 0x800000 are exact two's complement negations of each other, in both halves.
- R6: The result for the n-th accepted word (counting from 0) becomes valid in the cycle after word n+2 is accepted. Without an accepted input, `iq_word` and `iq_last` do not change and `iq_valid` cannot rise.
- R7: `iq_last` on each output equals `ph_last` of the phase word it was computed from.
- R8: While `iq_valid` is 1 and `iq_ready` is 0, `ph_ready` is 0. In the next cycle, `iq_valid` stays 1 and `iq_word` and `iq_last` are unchanged.
- R9: An output taken with no input accepted in the same cycle is presented once only: `iq_valid` is 0 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously, released on a clock edge |
| ph_valid | input | 1 | Phase word offered |
| ph_ready | output | 1 | Block can take a phase word |
| ph_word | input | 24 | Unsigned phase, fraction of a full turn |
| ph_last | input | 1 | End flag of the phase word |
| iq_valid | output | 1 | Phasor word offered |
| iq_ready | input | 1 | Downstream takes the phasor word |
| iq_word | output | 32 | {sine, cosine}, each Q2.14 |
| iq_last | output | 1 | End flag carried from the matching phase word |

## Verification
A single clock edge can do two things at once: hand the current result downstream and accept a new phase word. The accepted word pushes a different result into the output register. A wrong enable here would duplicate a result or lose one. The bench provokes this overlap with randomly chosen valid and ready levels on both sides, mixed with long stalls. Each cycle it compares the number of results taken against the number of words accepted. Each result taken must also match, in order, the accepted phase it belongs to.

// File: rtl/phasor_pkg.sv
`timescale 1ns/1ps
package phasor_pkg;

  localparam real TWO_PI = 6.283185307179586;

  // Number of registered stages between an accepted phase and the output.
  localparam int unsigned STAGES = 3;

  typedef enum logic [1:0] {
    QD_0 = 2'd0,
    QD_1 = 2'd1,
    QD_2 = 2'd2,
    QD_3 = 2'd3
  } quad_e;

  // Rounded magnitude of sin(idx * quarter_turn / 2**aw) scaled by 2**fw.
  function automatic int unsigned qtr_entry(input int unsigned idx,
                                            input int unsigned aw,
                                            input int unsigned fw);
    real ang;
    real amp;
    ang = TWO_PI * real'(idx) / (4.0 * real'(1 << aw));
    amp = $sin(ang) * real'(1 << fw);
    return $rtoi(amp + 0.5);
  endfunction

endpackage

// File: rtl/phasor_fold.sv
`timescale 1ns/1ps
// Stage 1: split the quantised angle into quadrant and table addresses.
module phasor_fold #(
  parameter int unsigned TBL_AW = 10
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      en,
  input  logic [TBL_AW+1:0]         angle,
  output phasor_pkg::quad_e         quad_q,
  output logic [TBL_AW-1:0]         adr_dir_q,
  output logic [TBL_AW-1:0]         adr_mir_q,
  output logic                      edge_q
);
  import phasor_pkg::*;

  quad_e             quad_n;
  logic [TBL_AW-1:0] adr_dir_n;
  logic [TBL_AW-1:0] adr_mir_n;
  logic              edge_n;

  always_comb begin
    quad_n    = quad_e'(angle[TBL_AW+1 -: 2]);
    adr_dir_n = angle[TBL_AW-1:0];
    // Mirror within the quarter: index (quarter - a) modulo the table size.
    adr_mir_n = '0 - angle[TBL_AW-1:0];
    // At a == 0 the mirrored index would be the quarter itself (value 1.0).
    edge_n    = (angle[TBL_AW-1:0] == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      quad_q    <= QD_0;
      adr_dir_q <= '0;
      adr_mir_q <= '0;
      edge_q    <= 1'b0;
    end else if (en) begin
      quad_q    <= quad_n;
      adr_dir_q <= adr_dir_n;
      adr_mir_q <= adr_mir_n;
      edge_q    <= edge_n;
    end
  end

endmodule

// File: rtl/phasor_qtr_rom.sv
`timescale 1ns/1ps
// Stage 2: quarter-wave table with a direct and a mirrored read port.
module phasor_qtr_rom #(
  parameter int unsigned TBL_AW = 10,
  parameter int unsigned FRAC_W = 14
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  en,
  input  phasor_pkg::quad_e     quad_i,
  input  logic [TBL_AW-1:0]     adr_dir,
  input  logic [TBL_AW-1:0]     adr_mir,
  input  logic                  edge_i,
  output phasor_pkg::quad_e     quad_q,
  output logic [FRAC_W:0]       mag_dir_q,
  output logic [FRAC_W:0]       mag_mir_q
);
  import phasor_pkg::*;

  localparam int unsigned MAG_W = FRAC_W + 1;
  localparam int unsigned DEPTH = 1 << TBL_AW;
  localparam logic [MAG_W-1:0] UNITY = MAG_W'(1 << FRAC_W);

  logic [DEPTH*MAG_W-1:0] tbl_flat;

  for (genvar k = 0; k < DEPTH; k++) begin : g_tbl
    localparam int unsigned ENTRY = qtr_entry(k, TBL_AW, FRAC_W);
    assign tbl_flat[k*MAG_W +: MAG_W] = MAG_W'(ENTRY);
  end

  logic [MAG_W-1:0] mag_dir_n;
  logic [MAG_W-1:0] mag_mir_n;

  always_comb begin
    mag_dir_n = tbl_flat[adr_dir*MAG_W +: MAG_W];
    mag_mir_n = edge_i ? UNITY : tbl_flat[adr_mir*MAG_W +: MAG_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      quad_q    <= QD_0;
      mag_dir_q <= '0;
      mag_mir_q <= '0;
    end else if (en) begin
      quad_q    <= quad_i;
      mag_dir_q <= mag_dir_n;
      mag_mir_q <= mag_mir_n;
    end
  end

endmodule

// File: rtl/phasor_unfold.sv
`timescale 1ns/1ps
// Stage 3: restore quadrant by swapping and negating, then pack {sin, cos}.
module phasor_unfold #(
  parameter int unsigned AMP_W  = 16,
  parameter int unsigned FRAC_W = 14
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  en,
  input  phasor_pkg::quad_e     quad,
  input  logic [FRAC_W:0]       mag_dir,
  input  logic [FRAC_W:0]       mag_mir,
  output logic [2*AMP_W-1:0]    word_q
);
  import phasor_pkg::*;

  localparam int unsigned MAG_W = FRAC_W + 1;
  localparam int unsigned PAD   = AMP_W - MAG_W;

  logic signed [AMP_W-1:0] dir_s;
  logic signed [AMP_W-1:0] mir_s;
  logic signed [AMP_W-1:0] cos_n;
  logic signed [AMP_W-1:0] sin_n;
  logic [2*AMP_W-1:0]      word_n;

  assign dir_s = signed'({{PAD{1'b0}}, mag_dir});
  assign mir_s = signed'({{PAD{1'b0}}, mag_mir});

  always_comb begin
    unique case (quad)
      QD_0: begin cos_n =  mir_s; sin_n =  dir_s; end
      QD_1: begin cos_n = -dir_s; sin_n =  mir_s; end
      QD_2: begin cos_n = -mir_s; sin_n = -dir_s; end
      default: begin cos_n = dir_s; sin_n = -mir_s; end
    endcase
    word_n = {sin_n, cos_n};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
    end else if (en) begin
      word_q <= word_n;
    end
  end

endmodule

// File: rtl/phasor_flow.sv
`timescale 1ns/1ps
// Valid / end-flag pipe that shifts only on an accepted input word.
module phasor_flow #(
  parameter int unsigned DEPTH = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  input  logic in_last,
  output logic in_ready,
  output logic adv,
  output logic out_valid,
  output logic out_last,
  input  logic out_ready
);

  logic [DEPTH-1:0] vld_q;
  logic [DEPTH-1:0] vld_n;
  logic [DEPTH-1:0] lst_q;
  logic [DEPTH-1:0] lst_n;

  always_comb begin
    in_ready = !(vld_q[DEPTH-1] && !out_ready);
    adv      = in_valid && in_ready;

    vld_n[0] = adv ? 1'b1    : vld_q[0];
    lst_n[0] = adv ? in_last : lst_q[0];
    for (int i = 1; i < DEPTH; i++) begin
      vld_n[i] = adv ? vld_q[i-1] : vld_q[i];
      lst_n[i] = adv ? lst_q[i-1] : lst_q[i];
    end
    // A consumed output with no replacement leaves the last stage empty.
    if (!adv) begin
      vld_n[DEPTH-1] = vld_q[DEPTH-1] && !out_ready;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      lst_q <= '0;
    end else begin
      vld_q <= vld_n;
      lst_q <= lst_n;
    end
  end

  assign out_valid = vld_q[DEPTH-1];
  assign out_last  = lst_q[DEPTH-1];

endmodule

// File: rtl/phasor_lut_gen.sv
`timescale 1ns/1ps
module phasor_lut_gen #(
  parameter int unsigned PHASE_W = 24,
  parameter int unsigned TBL_AW  = 10,
  parameter int unsigned AMP_W   = 16,
  parameter int unsigned FRAC_W  = 14
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ph_valid,
  output logic                 ph_ready,
  input  logic [PHASE_W-1:0]   ph_word,
  input  logic                 ph_last,
  output logic                 iq_valid,
  input  logic                 iq_ready,
  output logic [2*AMP_W-1:0]   iq_word,
  output logic                 iq_last
);
  import phasor_pkg::*;

  localparam int unsigned ANG_W  = TBL_AW + 2;
  localparam int unsigned DROP_W = PHASE_W - ANG_W;

  logic               adv;
  quad_e              quad_s1;
  quad_e              quad_s2;
  logic [TBL_AW-1:0]  adr_dir_s1;
  logic [TBL_AW-1:0]  adr_mir_s1;
  logic               edge_s1;
  logic [FRAC_W:0]    mag_dir_s2;
  logic [FRAC_W:0]    mag_mir_s2;

  if (DROP_W > 0) begin : g_drop
    logic unused_low_bits;
    assign unused_low_bits = ^ph_word[DROP_W-1:0];
  end

  phasor_flow #(
    .DEPTH (STAGES)
  ) i_flow (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (ph_valid),
    .in_last   (ph_last),
    .in_ready  (ph_ready),
    .adv       (adv),
    .out_valid (iq_valid),
    .out_last  (iq_last),
    .out_ready (iq_ready)
  );

  phasor_fold #(
    .TBL_AW (TBL_AW)
  ) i_fold (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (adv),
    .angle     (ph_word[PHASE_W-1 -: ANG_W]),
    .quad_q    (quad_s1),
    .adr_dir_q (adr_dir_s1),
    .adr_mir_q (adr_mir_s1),
    .edge_q    (edge_s1)
  );

  phasor_qtr_rom #(
    .TBL_AW (TBL_AW),
    .FRAC_W (FRAC_W)
  ) i_rom (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (adv),
    .quad_i    (quad_s1),
    .adr_dir   (adr_dir_s1),
    .adr_mir   (adr_mir_s1),
    .edge_i    (edge_s1),
    .quad_q    (quad_s2),
    .mag_dir_q (mag_dir_s2),
    .mag_mir_q (mag_mir_s2)
  );

  phasor_unfold #(
    .AMP_W  (AMP_W),
    .FRAC_W (FRAC_W)
  ) i_unfold (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (adv),
    .quad    (quad_s2),
    .mag_dir (mag_dir_s2),
    .mag_mir (mag_mir_s2),
    .word_q  (iq_word)
  );

endmodule

// File: rtl/phasor_lut_gen_chk.sv
`timescale 1ns/1ps
module phasor_lut_gen_chk #(
  parameter int unsigned AMP_W  = 16,
  parameter int unsigned FRAC_W = 14
) (
  input logic               clk,
  input logic               rst_n,
  input logic               ph_valid,
  input logic               ph_ready,
  input logic               iq_valid,
  input logic               iq_ready,
  input logic [2*AMP_W-1:0] iq_word,
  input logic               iq_last
);

  localparam int LIMIT = 1 << FRAC_W;

  logic signed [AMP_W-1:0] cos_v;
  logic signed [AMP_W-1:0] sin_v;
  assign cos_v = iq_word[AMP_W-1:0];
  assign sin_v = iq_word[2*AMP_W-1:AMP_W];

  // R1
  p_idle_in_reset_r1: assert property (@(posedge clk)
    !rst_n |-> !iq_valid);

  // R3
  p_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    iq_valid |-> (int'(cos_v) >= -LIMIT) && (int'(cos_v) <= LIMIT) &&
                 (int'(sin_v) >= -LIMIT) && (int'(sin_v) <= LIMIT));

  // R6
  p_rise_after_accept_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(iq_valid) |-> $past(ph_valid && ph_ready));

  // R6
  p_frozen_without_accept_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(ph_valid && ph_ready) |=> $stable(iq_word) && $stable(iq_last));

  // R8
  p_hold_on_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (iq_valid && !iq_ready) |=> iq_valid && $stable(iq_word) && $stable(iq_last));

  // R9
  p_single_take_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (iq_valid && iq_ready && !(ph_valid && ph_ready)) |=> !iq_valid);

endmodule

bind phasor_lut_gen phasor_lut_gen_chk #(
  .AMP_W  (AMP_W),
  .FRAC_W (FRAC_W)
) i_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .ph_valid (ph_valid),
  .ph_ready (ph_ready),
  .iq_valid (iq_valid),
  .iq_ready (iq_ready),
  .iq_word  (iq_word),
  .iq_last  (iq_last)
);

// File: tb/test_phasor_lut_gen.sv
`timescale 1ns/1ps
module test_phasor_lut_gen;

  localparam int WD_CYCLES = 100000;

  logic        clk;
  logic        rst_n;
  logic        ph_valid;
  logic        ph_ready;
  logic [23:0] ph_word;
  logic        ph_last;
  logic        iq_valid;
  logic        iq_ready;
  logic [31:0] iq_word;
  logic        iq_last;

  int n_chk  = 0;
  int n_fail = 0;
  int acc    = 0;
  int tk     = 0;

  logic [23:0] exp_ph[$];
  logic        exp_lst[$];
  logic [31:0] got[$];

  logic        was_stall = 1'b0;
  logic [31:0] stall_word;
  logic        stall_last;

  phasor_lut_gen i_phasor_lut_gen (
    .clk      (clk),
    .rst_n    (rst_n),
    .ph_valid (ph_valid),
    .ph_ready (ph_ready),
    .ph_word  (ph_word),
    .ph_last  (ph_last),
    .iq_valid (iq_valid),
    .iq_ready (iq_ready),
    .iq_word  (iq_word),
    .iq_last  (iq_last)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic int rnd(input real x);
    return (x >= 0.0) ? $rtoi(x + 0.5) : -$rtoi(0.5 - x);
  endfunction

  // Expected {sin, cos} from the 12 most significant phase bits.
  function automatic logic [31:0] model(input logic [23:0] ph);
    real a;
    int  c;
    int  s;
    a = 6.283185307179586 * real'(ph[23:12]) / 4096.0;
    c = rnd(16384.0 * $cos(a));
    s = rnd(16384.0 * $sin(a));
    return {s[15:0], c[15:0]};
  endfunction

  function automatic bit near(input logic [15:0] a, input logic [15:0] b);
    int d;
    d = int'($signed(a)) - int'($signed(b));
    return (d <= 2) && (d >= -2);
  endfunction

  task automatic step(input logic sv, input logic [23:0] ph, input logic lst, input logic mr);
    int          exp_tk;
    logic [31:0] e;
    logic [23:0] p;
    logic        l;
    @(negedge clk);
    ph_valid = sv;
    ph_word  = ph;
    ph_last  = lst;
    iq_ready = mr;
    #1;
    // R6: result n is presented only between accepts n+2 and n+3
    exp_tk = iq_valid ? acc - 3 : ((acc > 2) ? acc - 2 : 0);
    chk(tk == exp_tk, "R6 taken vs accepted", tk, exp_tk);
    if (was_stall) begin
      chk(iq_valid == 1'b1, "R8 valid held", iq_valid, 1);
      chk({iq_last, iq_word} == {stall_last, stall_word}, "R8 word held",
          {iq_last, iq_word}, {stall_last, stall_word});
    end
    if (iq_valid && !iq_ready) begin
      chk(ph_ready == 1'b0, "R8 ready low on stall", ph_ready, 0);
    end
    was_stall  = iq_valid && !iq_ready;
    stall_word = iq_word;
    stall_last = iq_last;
    if (iq_valid && iq_ready) begin
      if (exp_ph.size() > 0) begin
        p = exp_ph.pop_front();
        l = exp_lst.pop_front();
        e = model(p);
        chk(near(iq_word[15:0], e[15:0]) && near(iq_word[31:16], e[31:16]),
            "R3 phasor value", iq_word, e);
        chk(iq_last == l, "R7 end flag", iq_last, l);
      end else begin
        chk(1'b0, "R6 output without input", iq_word, 0);
      end
      got.push_back(iq_word);
      tk++;
    end
    if (ph_valid && ph_ready) begin
      exp_ph.push_back(ph_word);
      exp_lst.push_back(ph_last);
      acc++;
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    #(4 * WD_CYCLES);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual %0d cycles expected completion", WD_CYCLES);
    summary();
    $finish;
  end

  initial begin
    int seed;
    seed     = $urandom(32'h1F2E_3D4C);
    rst_n    = 1'b0;
    ph_valid = 1'b0;
    ph_word  = '0;
    ph_last  = 1'b0;
    iq_ready = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(iq_valid == 1'b0, "R1 valid in reset", iq_valid, 0);
    chk(ph_ready == 1'b1, "R1 ready in reset", ph_ready, 1);
    rst_n = 1'b1;
    step(1'b0, 24'h0, 1'b0, 1'b0);
    chk(iq_valid == 1'b0, "R1 valid after reset", iq_valid, 0);
    chk(ph_ready == 1'b1, "R1 ready after reset", ph_ready, 1);

    // Directed words: cardinal points, low-bit pair, half-turn pair.
    step(1'b1, 24'h000000, 1'b0, 1'b1);
    step(1'b1, 24'h400000, 1'b1, 1'b1);
    step(1'b1, 24'h800000, 1'b0, 1'b1);
    step(1'b1, 24'hC00000, 1'b1, 1'b1);
    step(1'b1, 24'h123000, 1'b0, 1'b1);
    step(1'b1, 24'h123FFF, 1'b0, 1'b1);
    step(1'b1, 24'h2AB000, 1'b1, 1'b1);
    step(1'b1, 24'hAAB000, 1'b0, 1'b1);
    step(1'b1, 24'h000000, 1'b0, 1'b1);
    step(1'b1, 24'h000000, 1'b0, 1'b1);
    repeat (4) step(1'b0, 24'h0, 1'b0, 1'b1);
    // R6: two dummies still inside, nothing leaves without new accepts
    chk(iq_valid == 1'b0, "R6 no output while idle", iq_valid, 0);
    chk(got.size() == 8, "R6 flushed count", got.size(), 8);
    if (got.size() >= 8) begin
      chk(got[0] == 32'h0000_4000, "R4 phase 0", got[0], 32'h0000_4000);
      chk(got[1] == 32'h4000_0000, "R4 quarter turn", got[1], 32'h4000_0000);
      chk(got[2] == 32'h0000_C000, "R4 half turn", got[2], 32'h0000_C000);
      chk(got[3] == 32'hC000_0000, "R4 three quarters", got[3], 32'hC000_0000);
      chk(got[4] == got[5], "R2 low bits ignored", got[5], got[4]);
      chk({16'(-got[6][31:16]), 16'(-got[6][15:0])} == got[7], "R5 half-turn negation",
          got[7], {16'(-got[6][31:16]), 16'(-got[6][15:0])});
    end

    // Random traffic with stalls on both sides.
    for (int i = 0; i < 3000; i++) begin
      logic sv;
      logic mr;
      sv = (($urandom % 10) < 7);
      mr = ((i / 200) % 4 == 3) ? 1'b0 : (($urandom % 10) < 6);
      step(sv, 24'($urandom), 1'($urandom % 2), mr);
    end

    // Drain with dummy words, then idle.
    repeat (6) step(1'b1, 24'h0, 1'b0, 1'b1);
    repeat (3) step(1'b0, 24'h0, 1'b0, 1'b1);
    chk(iq_valid == 1'b0, "R9 no repeat after take", iq_valid, 0);

    summary();
    $finish;
  end

endmodule